// File: doc/BRIEF.md
# Sectored Cache Tag Directory

This block holds the tags and line states for a 32 KB, two-way set-associative writeback data cache. Storage is grouped in 64-byte sectors. Each sector is a pair of adjacent 32-byte lines under one shared tag, and each of the two lines keeps its own MESI state. A lookup takes one address and answers in one of three ways:

- a hit, with the way;
- a line miss, where the tag is present but the addressed line is Invalid;
- a sector miss, where no way holds the tag.

Each answer leads to different follow-up work. A line miss only asks for the missing line. A sector miss first picks a victim by the per-set LRU bit. It then asks for a writeback of every dirty line in that victim, installs the new tag and asks for the line. A write to a Shared line asks for a write-notify first.

The block holds no data, drives no bus and sees no snoops. It only raises the writeback, fill and notify requests, each held until its acknowledge arrives, and it updates its own state when each one completes. Only one access is in flight at a time. The requester waits for `req_ready_o`. A miss never performs the access that caused it, so the requester issues the access again after the fill.

Top module: `sdir_top`

## Requirements
- R1: The address is split into a byte offset in bits [4:0], a line select in bit 5 (0 = lower line), a set index in bits [13:6] and a tag in bits [31:14]. Addresses that differ only in the offset give the same lookup result.
- R2: A synchronous reset invalidates every line by clearing one set per clock. `busy_o` is high for exactly 256 cycles after reset is released. After the sweep, every lookup is a sector miss.
- R3: One cycle after an accepted request, `resp_valid_o` is high with exactly one of hit, sector miss and line miss set. `resp_way_o` gives the matching way on a hit or line miss, and the victim way on a sector miss.
- R4: A line miss raises a fill request for that line in the matching way. It changes neither the tag nor the sibling line, which still hits afterwards.
- R5: On a sector miss the victim way is the set's LRU bit. One writeback is requested for each Modified victim line, lower line first. Each writeback is held until `wb_ack_i`, and its line address is {victim tag, set, line, 5'b0}. The new tag is then installed with both lines Invalid, and a fill is requested.
- R6: `fill_req_o` is held until `fill_done_i`, with `fill_addr_o` set to the requested line address and offset zero. The line then becomes Shared if `fill_shared_i` is 1, and Exclusive otherwise. A missing write is not applied.
- R7: A write hit to an Exclusive or Modified line makes it Modified with no external request, and the block is ready again on the next cycle.
- R8: A write hit to a Shared line holds `notify_req_o` until `notify_ack_i`, and only then marks the line Modified. A later write to the same line raises no notify.
- R9: Every hit, line miss and allocation sets the set's LRU bit to the other way.
- R10: A request is accepted only while `req_ready_o` is high. `req_ready_o` is low during the reset sweep and while a writeback, fill or notify is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the invalidation sweep |
| busy_o | output | 1 | Invalidation sweep in progress |
| req_valid_i | input | 1 | Lookup request |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_addr_i | input | 32 | Byte address of the access |
| req_ready_o | output | 1 | Directory idle and able to accept a request |
| resp_valid_o | output | 1 | Lookup result valid (one cycle) |
| resp_hit_o | output | 1 | Hit |
| resp_sector_miss_o | output | 1 | No way holds the tag |
| resp_line_miss_o | output | 1 | Tag present, addressed line Invalid |
| resp_way_o | output | 1 | Hit/line-miss way, or victim way |
| wb_req_o | output | 1 | Writeback request for a Modified victim line |
| wb_addr_o | output | 32 | Line address to write back |
| wb_ack_i | input | 1 | Writeback accepted |
| fill_req_o | output | 1 | Line fill request |
| fill_addr_o | output | 32 | Line address to fill |
| fill_way_o | output | 1 | Way that receives the fill |
| fill_done_i | input | 1 | Fill complete |
| fill_shared_i | input | 1 | Filled line is held by another cache |
| notify_req_o | output | 1 | Write-notify request for a Shared line |
| notify_addr_o | output | 32 | Line address of the notify |
| notify_ack_i | input | 1 | Notify acknowledged |

## Verification
The lookup result is registered. It appears on the cycle after the accepting edge, and the bench samples it on the falling edge that follows the request. A writeback is asserted on that same cycle. A fill follows one cycle after the last writeback acknowledge, because of the single allocation cycle, or at once on a line miss. The bench therefore waits on each request level within a short bound instead of counting fixed delays. Every request address, way and order is compared against a behavioural model of tags, states and LRU bits, and that model is updated only when the bench's own acknowledge completes. The reset check counts the falling edges on which `busy_o` stays high.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        F_SWEEP,
        F_IDLE,
        F_WB,
        F_ALLOC,
        F_FILL,
        F_NOTIFY
    } fsm_e;

endpackage

// File: rtl/sdir_store.sv
module sdir_store #(
    parameter int TAG_W = 18,
    parameter int SET_W = 8
) (
    input  logic                        clk,
    input  logic [SET_W-1:0]            rd_idx,
    input  logic [SET_W-1:0]            wr_idx,
    input  logic                        clr_en,
    input  logic                        tag_we,
    input  logic                        st_we,
    input  logic                        lru_we,
    input  logic                        wr_way,
    input  logic                        wr_line,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [1:0]                  wr_st,
    input  logic                        wr_lru,
    output logic [1:0][TAG_W-1:0]       rd_tag,
    output logic [1:0]                  rd_tv,
    output logic [1:0][1:0][1:0]        rd_st,
    output logic                        rd_lru
);
    import sdir_pkg::*;

    localparam int NSETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_m [NSETS][2];
    logic             tv_m  [NSETS][2];
    logic [1:0]       st_m  [NSETS][2][2];
    logic             lru_m [NSETS];

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign rd_tag[w] = tag_m[rd_idx][w];
        assign rd_tv[w]  = tv_m[rd_idx][w];
        for (genvar l = 0; l < 2; l++) begin : g_line
            assign rd_st[w][l] = st_m[rd_idx][w][l];
        end
    end
    assign rd_lru = lru_m[rd_idx];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            for (int w = 0; w < 2; w++) begin
                tv_m[wr_idx][w]    <= 1'b0;
                st_m[wr_idx][w][0] <= ST_I;
                st_m[wr_idx][w][1] <= ST_I;
            end
            lru_m[wr_idx] <= 1'b0;
        end else begin
            if (tag_we) begin
                tag_m[wr_idx][wr_way]   <= wr_tag;
                tv_m[wr_idx][wr_way]    <= 1'b1;
                st_m[wr_idx][wr_way][0] <= ST_I;
                st_m[wr_idx][wr_way][1] <= ST_I;
            end
            if (st_we) begin
                st_m[wr_idx][wr_way][wr_line] <= wr_st;
            end
            if (lru_we) begin
                lru_m[wr_idx] <= wr_lru;
            end
        end
    end

endmodule

// File: rtl/sdir_match.sv
module sdir_match #(
    parameter int TAG_W = 18
) (
    input  logic [TAG_W-1:0]            tag,
    input  logic                        line,
    input  logic [1:0][TAG_W-1:0]       way_tag,
    input  logic [1:0]                  way_tv,
    input  logic [1:0][1:0][1:0]        way_st,
    output logic [1:0]                  match,
    output logic                        hit,
    output logic                        line_miss,
    output logic                        sector_miss,
    output logic                        hit_way,
    output logic [1:0]                  line_st
);
    import sdir_pkg::*;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = way_tv[w] && (way_tag[w] == tag);
    end

    assign hit_way     = match[1];
    assign line_st     = way_st[hit_way][line];
    assign sector_miss = ~|match;
    assign hit         = (|match) && (line_st != ST_I);
    assign line_miss   = (|match) && (line_st == ST_I);

endmodule

// File: rtl/sdir_top.sv
module sdir_top #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              busy_o,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              resp_valid_o,
    output logic              resp_hit_o,
    output logic              resp_sector_miss_o,
    output logic              resp_line_miss_o,
    output logic              resp_way_o,
    output logic              wb_req_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    input  logic              wb_ack_i,
    output logic              fill_req_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    output logic              fill_way_o,
    input  logic              fill_done_i,
    input  logic              fill_shared_i,
    output logic              notify_req_o,
    output logic [ADDR_W-1:0] notify_addr_o,
    input  logic              notify_ack_i
);
    import sdir_pkg::*;

    localparam int TAG_W = ADDR_W - SET_W - OFF_W - 1;
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int LSB_T = OFF_W + SET_W + 1;
    localparam logic [SET_W-1:0] LAST_SET = {SET_W{1'b1}};

    typedef struct packed {
        fsm_e             fsm;
        logic [BLK_W-1:0] blk;
        logic             wr;
        logic             way;
        logic             line;
        logic [SET_W-1:0] ctr;
        logic             rv;
        logic             rhit;
        logic             rway;
        logic             rsm;
        logic             rlm;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [BLK_W-1:0]           lk_blk;
    logic [SET_W-1:0]           rd_idx, wr_idx;
    logic [TAG_W-1:0]           lk_tag;
    logic                       lk_line;
    logic                       clr_en, tag_we, st_we, lru_we, wr_way, wr_line, wr_lru;
    logic [1:0]                 wr_st;
    logic [1:0][TAG_W-1:0]      rd_tag;
    logic [1:0]                 rd_tv;
    logic [1:0][1:0][1:0]       rd_st;
    logic                       rd_lru;
    logic [1:0]                 match;
    logic                       hit, line_miss, sector_miss, hit_way;
    logic [1:0]                 line_st;

    // Lookup address: the live request while idle, the held access otherwise.
    assign lk_blk  = (c_q.fsm == F_IDLE) ? req_addr_i[ADDR_W-1:OFF_W] : c_q.blk;
    assign rd_idx  = lk_blk[SET_W:1];
    assign lk_line = lk_blk[0];
    assign lk_tag  = lk_blk[BLK_W-1:SET_W+1];
    assign wr_idx  = (c_q.fsm == F_SWEEP) ? c_q.ctr : rd_idx;

    sdir_store #(.TAG_W(TAG_W), .SET_W(SET_W)) i_store (
        .clk(clk), .rd_idx(rd_idx), .wr_idx(wr_idx), .clr_en(clr_en),
        .tag_we(tag_we), .st_we(st_we), .lru_we(lru_we), .wr_way(wr_way),
        .wr_line(wr_line), .wr_tag(lk_tag), .wr_st(wr_st), .wr_lru(wr_lru),
        .rd_tag(rd_tag), .rd_tv(rd_tv), .rd_st(rd_st), .rd_lru(rd_lru)
    );

    sdir_match #(.TAG_W(TAG_W)) i_match (
        .tag(lk_tag), .line(lk_line), .way_tag(rd_tag), .way_tv(rd_tv),
        .way_st(rd_st), .match(match), .hit(hit), .line_miss(line_miss),
        .sector_miss(sector_miss), .hit_way(hit_way), .line_st(line_st)
    );

    always_comb begin
        c_d     = c_q;
        c_d.rv  = 1'b0;
        clr_en  = 1'b0;
        tag_we  = 1'b0;
        st_we   = 1'b0;
        lru_we  = 1'b0;
        wr_way  = c_q.way;
        wr_line = lk_line;
        wr_st   = ST_M;
        wr_lru  = ~c_q.way;
        case (c_q.fsm)
            F_SWEEP: begin
                clr_en  = 1'b1;
                c_d.ctr = c_q.ctr + 1'b1;
                if (c_q.ctr == LAST_SET) c_d.fsm = F_IDLE;
            end
            F_IDLE: begin
                if (req_valid_i) begin
                    c_d.blk  = req_addr_i[ADDR_W-1:OFF_W];
                    c_d.wr   = req_write_i;
                    c_d.rv   = 1'b1;
                    c_d.rhit = hit;
                    c_d.rlm  = line_miss;
                    c_d.rsm  = sector_miss;
                    if (!sector_miss) begin
                        c_d.rway = hit_way;
                        c_d.way  = hit_way;
                        lru_we   = 1'b1;
                        wr_lru   = ~hit_way;
                        wr_way   = hit_way;
                        if (line_miss) begin
                            c_d.fsm = F_FILL;
                        end else if (req_write_i) begin
                            if (line_st == ST_S) c_d.fsm = F_NOTIFY;
                            else st_we = 1'b1;
                        end
                    end else begin
                        c_d.rway = rd_lru;
                        c_d.way  = rd_lru;
                        if (rd_st[rd_lru][0] == ST_M) begin
                            c_d.fsm  = F_WB;
                            c_d.line = 1'b0;
                        end else if (rd_st[rd_lru][1] == ST_M) begin
                            c_d.fsm  = F_WB;
                            c_d.line = 1'b1;
                        end else begin
                            c_d.fsm = F_ALLOC;
                        end
                    end
                end
            end
            F_WB: begin
                if (wb_ack_i) begin
                    if (!c_q.line && rd_st[c_q.way][1] == ST_M) c_d.line = 1'b1;
                    else c_d.fsm = F_ALLOC;
                end
            end
            F_ALLOC: begin
                tag_we  = 1'b1;
                lru_we  = 1'b1;
                c_d.fsm = F_FILL;
            end
            F_FILL: begin
                if (fill_done_i) begin
                    st_we   = 1'b1;
                    wr_st   = fill_shared_i ? ST_S : ST_E;
                    c_d.fsm = F_IDLE;
                end
            end
            F_NOTIFY: begin
                if (notify_ack_i) begin
                    st_we   = 1'b1;
                    c_d.fsm = F_IDLE;
                end
            end
            default: c_d.fsm = F_SWEEP;
        endcase
        if (rst) begin
            c_d     = '0;
            c_d.fsm = F_SWEEP;
            clr_en  = 1'b0;
            tag_we  = 1'b0;
            st_we   = 1'b0;
            lru_we  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign busy_o             = (c_q.fsm == F_SWEEP);
    assign req_ready_o        = (c_q.fsm == F_IDLE);
    assign resp_valid_o       = c_q.rv;
    assign resp_hit_o         = c_q.rhit;
    assign resp_sector_miss_o = c_q.rsm;
    assign resp_line_miss_o   = c_q.rlm;
    assign resp_way_o         = c_q.rway;
    assign wb_req_o           = (c_q.fsm == F_WB);
    assign wb_addr_o          = {rd_tag[c_q.way], rd_idx, c_q.line, {OFF_W{1'b0}}};
    assign fill_req_o         = (c_q.fsm == F_FILL);
    assign fill_addr_o        = {c_q.blk, {OFF_W{1'b0}}};
    assign fill_way_o         = c_q.way;
    assign notify_req_o       = (c_q.fsm == F_NOTIFY);
    assign notify_addr_o      = {c_q.blk, {OFF_W{1'b0}}};

    // Stored tags never produce two matches once the sweep is done.
    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        (c_q.fsm != F_SWEEP && c_q.fsm != F_IDLE) |-> $onehot0(match));

    assert_resp_kind_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |-> ($countones({resp_hit_o, resp_sector_miss_o, resp_line_miss_o}) == 1));

    assert_wb_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_addr_o)));

    assert_wb_upper_last_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_req_o && wb_ack_i && wb_addr_o[OFF_W]) |=> !wb_req_o);

    assert_fill_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_req_o && !fill_done_i) |=> (fill_req_o && $stable(fill_addr_o)));

    assert_notify_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (notify_req_o && !notify_ack_i) |=> notify_req_o);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> !(busy_o || wb_req_o || fill_req_o || notify_req_o));

    assert_tag_field_R1: assert property (@(posedge clk) disable iff (rst)
        fill_req_o |-> (fill_addr_o[ADDR_W-1:LSB_T] == lk_tag));

endmodule

// File: tb/test_sdir_top.sv
`timescale 1ns/1ps
module test_sdir_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy_o, req_ready_o;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        resp_valid_o, resp_hit_o, resp_sector_miss_o, resp_line_miss_o, resp_way_o;
    logic        wb_req_o, fill_req_o, notify_req_o, fill_way_o;
    logic [31:0] wb_addr_o, fill_addr_o, notify_addr_o;
    logic        wb_ack_i = 1'b0, fill_done_i = 1'b0, fill_shared_i = 1'b0, notify_ack_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdir_top i_sdir_top (
        .clk(clk), .rst(rst), .busy_o(busy_o),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
        .resp_sector_miss_o(resp_sector_miss_o), .resp_line_miss_o(resp_line_miss_o),
        .resp_way_o(resp_way_o), .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o),
        .wb_ack_i(wb_ack_i), .fill_req_o(fill_req_o), .fill_addr_o(fill_addr_o),
        .fill_way_o(fill_way_o), .fill_done_i(fill_done_i), .fill_shared_i(fill_shared_i),
        .notify_req_o(notify_req_o), .notify_addr_o(notify_addr_o), .notify_ack_i(notify_ack_i)
    );

    // Behavioural directory model
    logic [17:0] m_tag [256][2];
    bit          m_tv  [256][2];
    logic [1:0]  m_st  [256][2][2];   // 0=I 1=S 2=E 3=M
    bit          m_lru [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [17:0] t, input logic [7:0] s,
                                       input bit ln, input logic [4:0] off);
        return {t, s, ln, off};
    endfunction

    function automatic bit sig(input int which);
        case (which)
            0: return wb_req_o;
            1: return fill_req_o;
            default: return notify_req_o;
        endcase
    endfunction

    task automatic wait_for(input int which, output bit ok);
        ok = 0;
        for (int n = 0; n < 32; n++) begin
            if (sig(which)) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 256; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_tv[s][w] = 0; m_st[s][w][0] = 0; m_st[s][w][1] = 0;
            end
        end
    endtask

    task automatic do_reset();
        int cnt = 0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        chk(!req_ready_o, "R10", "ready during sweep", {31'b0, req_ready_o}, 0);
        while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == 256, "R2", "busy cycles", cnt, 256);
        chk(req_ready_o, "R10", "ready after sweep", {31'b0, req_ready_o}, 1);
    endtask

    // One access, checked in full against the model.
    task automatic access(input logic [31:0] a, input bit wr, input bit sh);
        logic [7:0]  s  = a[13:6];
        logic [17:0] t  = a[31:14];
        bit          ln = a[5];
        int          mw = -1;
        bit          ok;
        bit          exp_hit, exp_lm, exp_sm, exp_way;
        logic [31:0] la = {a[31:5], 5'b0};
        for (int w = 0; w < 2; w++) if (m_tv[s][w] && m_tag[s][w] == t) mw = w;
        exp_sm  = (mw < 0);
        exp_way = exp_sm ? m_lru[s] : mw[0];
        exp_hit = !exp_sm && m_st[s][exp_way][ln] != 0;
        exp_lm  = !exp_sm && m_st[s][exp_way][ln] == 0;

        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(resp_valid_o, "R3", "resp_valid", {31'b0, resp_valid_o}, 1);
        chk(resp_hit_o == exp_hit, "R3", "hit", {31'b0, resp_hit_o}, {31'b0, exp_hit});
        chk(resp_line_miss_o == exp_lm, "R4", "line_miss", {31'b0, resp_line_miss_o}, {31'b0, exp_lm});
        chk(resp_sector_miss_o == exp_sm, "R5", "sector_miss", {31'b0, resp_sector_miss_o}, {31'b0, exp_sm});
        chk(resp_way_o == exp_way, "R9", "way", {31'b0, resp_way_o}, {31'b0, exp_way});

        if (exp_hit) begin
            m_lru[s] = !exp_way;
            if (wr && m_st[s][exp_way][ln] == 1) begin
                wait_for(2, ok);
                chk(ok && notify_addr_o == la, "R8", "notify addr", notify_addr_o, la);
                repeat (2) @(negedge clk);
                chk(notify_req_o, "R8", "notify held", {31'b0, notify_req_o}, 1);
                notify_ack_i = 1'b1; @(negedge clk); notify_ack_i = 1'b0;
                m_st[s][exp_way][ln] = 3;
            end else if (wr) begin
                chk(req_ready_o && !notify_req_o, "R7", "write hit ready, no notify",
                    {30'b0, req_ready_o, notify_req_o}, 2);
                m_st[s][exp_way][ln] = 3;
            end
        end else begin
            if (exp_sm) begin
                for (int l = 0; l < 2; l++) begin
                    if (m_st[s][exp_way][l] == 3) begin
                        logic [31:0] wa = mk(m_tag[s][exp_way], s, l[0], 5'd0);
                        wait_for(0, ok);
                        chk(ok && wb_addr_o == wa, "R5", "writeback addr", wb_addr_o, wa);
                        wb_ack_i = 1'b1; @(negedge clk); wb_ack_i = 1'b0;
                    end
                end
                m_tag[s][exp_way] = t; m_tv[s][exp_way] = 1;
                m_st[s][exp_way][0] = 0; m_st[s][exp_way][1] = 0;
            end
            m_lru[s] = !exp_way;
            wait_for(1, ok);
            chk(ok && !wb_req_o && fill_addr_o == la, "R6", "fill addr", fill_addr_o, la);
            chk(fill_way_o == exp_way, "R6", "fill way", {31'b0, fill_way_o}, {31'b0, exp_way});
            @(negedge clk);
            chk(fill_req_o, "R6", "fill held", {31'b0, fill_req_o}, 1);
            fill_done_i = 1'b1; fill_shared_i = sh;
            @(negedge clk);
            fill_done_i = 1'b0; fill_shared_i = 1'b0;
            m_st[s][exp_way][ln] = sh ? 2'd1 : 2'd2;
        end
    endtask

    // Scenarios
    task automatic t_basic();   // R1 R3 R6 R7
        logic [31:0] a = mk(18'h00011, 8'd1, 0, 5'd0);
        access(a, 0, 0);                       // sector miss, fill Exclusive
        access(a, 0, 0);                       // hit
        access(a | 32'h1b, 0, 0);              // R1: offset ignored
        access(a | 32'h04, 1, 0);              // R7: write hit Exclusive
    endtask

    task automatic t_line_miss();   // R4
        logic [31:0] a = mk(18'h00011, 8'd1, 0, 5'd0);
        access(a | 32'h20, 0, 1);              // sibling line miss
        access(a, 0, 0);                       // sibling still hits (R4)
        access(a | 32'h20, 0, 0);              // filled line hits
    endtask

    task automatic t_shared_write();   // R8
        logic [31:0] b = mk(18'h00222, 8'd7, 1, 5'd3);
        access(b, 1, 1);                       // miss: write not applied, fill Shared
        access(b, 1, 0);                       // write hit Shared -> notify
        access(b, 1, 0);                       // now Modified, no notify
    endtask

    task automatic t_dirty_victim();   // R5 R9
        logic [7:0] s = 8'd40;
        access(mk(18'h00100, s, 0, 0), 0, 0);
        access(mk(18'h00100, s, 1, 0), 0, 0);
        access(mk(18'h00100, s, 0, 0), 1, 0);
        access(mk(18'h00100, s, 1, 0), 1, 0);
        access(mk(18'h00200, s, 0, 0), 0, 0);  // other way
        access(mk(18'h00300, s, 1, 0), 0, 0);  // evicts two dirty lines
        access(mk(18'h00200, s, 0, 0), 0, 0);
    endtask

    task automatic t_lru();   // R9
        logic [7:0] s = 8'd200;
        for (int i = 0; i < 6; i++) access(mk(18'h01000 + 18'(i % 3), s, 0, 0), 0, i[0]);
        access(mk(18'h01000, s, 0, 0), 0, 0);
        access(mk(18'h01001, s, 0, 0), 0, 0);
        access(mk(18'h01000, s, 0, 0), 0, 0);
        access(mk(18'h01002, s, 0, 0), 0, 0);
    endtask

    task automatic t_reset_again();   // R2
        do_reset();
        access(mk(18'h00011, 8'd1, 0, 5'd0), 0, 0);  // former hit is now sector miss
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        t_basic();
        t_line_miss();
        t_shared_write();
        t_dirty_victim();
        t_lru();
        t_reset_again();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule